// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects line-side status and event sources into two host-readable interrupt registers. It drives an active-low interrupt request and a channel-indication flag.

Register 0 holds the hook and current-limit status bits and a reset-status bit. The hook and current-limit bits are filtered by persistence counters. Register 1 holds a set of plain level inputs and a caller-data request bit. A source latches a pending interrupt when its status changes and its mask bit is clear. The status bits themselves always follow their sources, whatever the mask says. Reading a register clears its pending bits, and the interrupt line releases once nothing is pending.

The persistence counters advance on a slow `tick` enable, for example one pulse per 0.5 ms. With that tick, the programmed counts 20 and 33 give 10 ms and 16.5 ms.

Each filter is a two-state machine:
- DB_STABLE moves to DB_QUALIFY when the raw input differs from the filtered bit.
- DB_QUALIFY returns to DB_STABLE when the raw input goes back to the filtered value, which restarts the qualification.
- DB_QUALIFY also returns to DB_STABLE when the count completes on a tick. The filtered bit then takes the raw value.

The channel flag is a second two-state machine:
- CH_RAISED is entered on any latched event and is also the state after reset.
- CH_RAISED moves to CH_QUIET once both registers have been read with no new event in between.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x20 (bit 5 is the reset-status bit), register 1 reads 0x00, `int_n` is 0 and `chan_ind` is 1.
- R2: The reset-status bit and its pending interrupt stay set until register 0 is read (`rd_stb`=1, `rd_sel`=0). From the next cycle on, register 0 shows bit 5 as 0, and `int_n` returns to 1 if nothing else is pending.
- R3: Register 1 bits [LVL_N:1] show `lvl_in` delayed by one clock. A change of any such bit in either direction, with its mask bit clear, drives `int_n` low in the next cycle.
- R4: A mask bit equal to 1 prevents its source from latching a pending interrupt. The status bit still updates.
- R5: Register 1 bit 0 shows `cid_req` delayed by one clock. Only a 0-to-1 change latches a pending interrupt; a 1-to-0 change latches none.
- R6: Register 0 bit 0 (hook) and bit 1 (current limit) are filtered. A filter enters qualification on the first clock at which its raw input differs from the filtered bit. Each later clock with `tick`=1 and the raw input still different counts one. The filtered bit takes the raw value in the clock where the count reaches the programmed value; a value of 0 acts as 1. If the raw input returns to the filtered value during qualification, the count restarts.
- R7: A completed filter transition latches a pending interrupt in that register when its mask bit is clear.
- R8: Reading a register clears its pending bits from the next cycle, except for events latched in the same cycle as the read, which remain pending. `int_n` is 1 exactly when no bit of either register is pending.
- R9: `chan_ind` becomes 1 on any latched event. It becomes 0 only after both registers have been read, in any order, with no latched event since the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Persistence counter enable |
| raw_hook | input | 1 | Unfiltered hook status |
| raw_lim | input | 1 | Unfiltered current-limit status |
| hook_cnt | input | CNT_W | Hook persistence count in ticks |
| lim_cnt | input | CNT_W | Current-limit persistence count in ticks |
| lvl_in | input | LVL_N | Plain level status sources |
| cid_req | input | 1 | Caller-data request source |
| mask0 | input | 8 | Interrupt mask for register 0, 1 = suppressed |
| mask1 | input | 8 | Interrupt mask for register 1, 1 = suppressed |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 1 | Register selected for reading |
| rd_data | output | 8 | Contents of the selected register |
| int_n | output | 1 | Active-low interrupt request |
| chan_ind | output | 1 | Channel-indication flag |

## Verification
The main collision is a host read and a new event landing in the same clock on the same register. The read clears older pending bits, while the fresh event must survive and keep both `int_n` and `chan_ind` asserted. This is provoked directly by toggling a level input in the cycle that reads register 1. It also occurs many times under random strobes and toggles. A cycle-level reference model in the bench judges every case, comparing the register contents, `int_n` and `chan_ind` every clock.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 2;
    localparam int NUM_DB   = 2;
    localparam int RST_BIT  = 5;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic {
        DB_STABLE  = 1'b0,
        DB_QUALIFY = 1'b1
    } db_state_e;

    typedef enum logic {
        CH_QUIET  = 1'b0,
        CH_RAISED = 1'b1
    } ch_state_e;
endpackage

// File: rtl/isc_debounce.sv
module isc_debounce
    import isc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             filt,
    output logic             flip
);
    localparam int CW1 = CNT_W + 1;

    db_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic             reached;

    assign reached = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_STABLE;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            DB_STABLE: begin
                if (raw != filt_q) begin
                    state_d = DB_QUALIFY;
                    cnt_d   = '0;
                end
            end
            DB_QUALIFY: begin
                if (raw == filt_q) begin
                    state_d = DB_STABLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (reached) begin
                        filt_d  = raw;
                        state_d = DB_STABLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_comb begin
        filt = filt_q;
        flip = (state_q == DB_QUALIFY) && (raw != filt_q) && tick && reached;
    end

    AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_q)); // R6
    AST_DB_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == filt_q) |=> $stable(filt_q)); // R6
endmodule

// File: rtl/isc_pending.sv
module isc_pending
    import isc_pkg::*;
#(
    parameter reg_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  reg_t ev,
    input  reg_t mask,
    input  logic clr,
    output reg_t pend
);
    reg_t pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= RST_VAL;
        else        pend_q <= (clr ? '0 : pend_q) | (ev & ~mask);
    end

    assign pend = pend_q;

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        |(mask & ~pend_q) |=> ((pend_q & $past(mask & ~pend_q)) == '0)); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr && ((ev & ~mask) == '0) |=> (pend_q == '0)); // R8
endmodule

// File: rtl/isc_channel.sv
module isc_channel
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic new_ev,
    input  logic rd_stb,
    input  logic rd_sel,
    output logic chan
);
    ch_state_e           state_q, state_d;
    logic [NUM_REGS-1:0] seen_q, seen_d, seen_or;

    assign seen_or = seen_q | (NUM_REGS'(1) << rd_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_RAISED;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            CH_QUIET: begin
                if (new_ev) begin
                    state_d = CH_RAISED;
                    seen_d  = '0;
                end
            end
            CH_RAISED: begin
                if (new_ev) begin
                    seen_d = '0;
                end else if (rd_stb) begin
                    if (&seen_or) begin
                        state_d = CH_QUIET;
                        seen_d  = '0;
                    end else begin
                        seen_d = seen_or;
                    end
                end
            end
        endcase
    end

    always_comb chan = (state_q == CH_RAISED);

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RAISED) && !rd_stb |=> (state_q == CH_RAISED)); // R9
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LVL_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw_hook,
    input  logic             raw_lim,
    input  logic [CNT_W-1:0] hook_cnt,
    input  logic [CNT_W-1:0] lim_cnt,
    input  logic [LVL_N-1:0] lvl_in,
    input  logic             cid_req,
    input  logic [REG_W-1:0] mask0,
    input  logic [REG_W-1:0] mask1,
    input  logic             rd_stb,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             int_n,
    output logic             chan_ind
);
    logic [NUM_DB-1:0]            db_raw, db_filt, db_flip;
    logic [NUM_DB-1:0][CNT_W-1:0] db_lim;
    logic [NUM_REGS-1:0][REG_W-1:0] ev, msk, stat, pend;
    logic [NUM_REGS-1:0]          clr_en;
    logic [LVL_N-1:0]             lvl_q;
    logic                         cid_q, rst_stat, new_ev;

    assign db_raw    = {raw_lim, raw_hook};
    assign db_lim[0] = hook_cnt;
    assign db_lim[1] = lim_cnt;

    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        isc_debounce #(.CNT_W(CNT_W)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (db_raw[g]),
            .limit (db_lim[g]),
            .filt  (db_filt[g]),
            .flip  (db_flip[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            cid_q    <= 1'b0;
            rst_stat <= 1'b1;
        end else begin
            lvl_q <= lvl_in;
            cid_q <= cid_req;
            if (rd_stb && !rd_sel) rst_stat <= 1'b0;
        end
    end

    assign ev[0]  = REG_W'(db_flip);
    assign ev[1]  = REG_W'({lvl_in ^ lvl_q, cid_req & ~cid_q});
    assign msk[0] = mask0;
    assign msk[1] = mask1;

    always_comb begin
        stat[0]          = REG_W'(db_filt);
        stat[0][RST_BIT] = rst_stat;
        stat[1]          = REG_W'({lvl_q, cid_q});
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign clr_en[g] = rd_stb && (rd_sel == 1'(g));
        isc_pending #(.RST_VAL(reg_t'(g == 0 ? (1 << RST_BIT) : 0))) u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev[g]),
            .mask  (msk[g]),
            .clr   (clr_en[g]),
            .pend  (pend[g])
        );
    end

    assign new_ev = |((ev[0] & ~msk[0]) | (ev[1] & ~msk[1]));

    isc_channel u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .new_ev (new_ev),
        .rd_stb (rd_stb),
        .rd_sel (rd_sel),
        .chan   (chan_ind)
    );

    assign rd_data = stat[rd_sel];
    assign int_n   = ~|pend;

    AST_CHAN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_ind |-> int_n); // R9
    AST_CID_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cid_q && !cid_req) |=> !$rose(pend[1][0])); // R5
    AST_RST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stat && !(rd_stb && !rd_sel) |=> rst_stat); // R2
    AST_LEVEL_ANYEDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (((lvl_in ^ lvl_q) & ~mask1[LVL_N:1]) != '0) |=> !int_n); // R3
endmodule

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;
    localparam int CNT_W = 8;
    localparam int LVL_N = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0, raw_hook = 1'b0, raw_lim = 1'b0, cid_req = 1'b0;
    logic [CNT_W-1:0] hook_cnt = 8'd3, lim_cnt = 8'd3;
    logic [LVL_N-1:0] lvl_in = '0;
    logic [7:0]       mask0 = '0, mask1 = '0;
    logic             rd_stb = 1'b0, rd_sel = 1'b0;
    logic [7:0]       rd_data;
    logic             int_n, chan_ind;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [1:0]       m_f, m_qual;
    int               m_c [2];
    logic [LVL_N-1:0] m_lvl;
    logic             m_cid, m_rst, m_chan;
    logic [7:0]       m_p0, m_p1;
    logic [1:0]       m_seen;

    irq_status_ctrl #(.CNT_W(CNT_W), .LVL_N(LVL_N)) u_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw_hook(raw_hook), .raw_lim(raw_lim),
        .hook_cnt(hook_cnt), .lim_cnt(lim_cnt), .lvl_in(lvl_in), .cid_req(cid_req),
        .mask0(mask0), .mask1(mask1), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .int_n(int_n), .chan_ind(chan_ind)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic sel);
        if (sel) return 8'({m_lvl, m_cid});
        return {2'b00, m_rst, 3'b000, m_f[1], m_f[0]};
    endfunction

    task automatic compare_all();
        chk("R8 int_n vs model", int'(int_n), int'(~|(m_p0 | m_p1)));
        chk("R9 chan_ind vs model", int'(chan_ind), int'(m_chan));
        chk(rd_sel ? "R3 reg1 vs model" : "R6 reg0 vs model", int'(rd_data), int'(exp_reg(rd_sel)));
    endtask

    // advance model by one clock using current inputs, then compare
    task automatic step();
        logic [7:0] ev0, ev1;
        logic       nev;
        ev0 = '0;
        for (int k = 0; k < 2; k++) begin
            logic r;
            int   lim;
            r   = (k == 0) ? raw_hook : raw_lim;
            lim = (k == 0) ? int'(hook_cnt) : int'(lim_cnt);
            if (lim == 0) lim = 1;
            if (!m_qual[k]) begin
                if (r != m_f[k]) begin m_qual[k] = 1'b1; m_c[k] = 0; end
            end else if (r == m_f[k]) begin
                m_qual[k] = 1'b0; m_c[k] = 0;
            end else if (tick) begin
                if (m_c[k] + 1 >= lim) begin
                    m_f[k] = r; m_qual[k] = 1'b0; m_c[k] = 0; ev0[k] = 1'b1;
                end else m_c[k]++;
            end
        end
        ev1 = 8'({lvl_in ^ m_lvl, cid_req & ~m_cid});
        nev = |((ev0 & ~mask0) | (ev1 & ~mask1));
        m_p0 = ((rd_stb && !rd_sel) ? 8'h00 : m_p0) | (ev0 & ~mask0);
        m_p1 = ((rd_stb && rd_sel) ? 8'h00 : m_p1) | (ev1 & ~mask1);
        if (rd_stb && !rd_sel) m_rst = 1'b0;
        if (nev) begin
            m_chan = 1'b1; m_seen = 2'b00;
        end else if (m_chan && rd_stb) begin
            m_seen = m_seen | (2'b01 << rd_sel);
            if (m_seen == 2'b11) begin m_chan = 1'b0; m_seen = 2'b00; end
        end
        m_lvl = lvl_in;
        m_cid = cid_req;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic read_reg(input logic sel);
        rd_stb = 1'b1; rd_sel = sel;
        step();
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_f = '0; m_qual = '0; m_c[0] = 0; m_c[1] = 0; m_lvl = '0; m_cid = 1'b0;
        m_rst = 1'b1; m_chan = 1'b1; m_p0 = 8'h20; m_p1 = 8'h00; m_seen = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reg0 after reset", int'(rd_data), 'h20);
        chk("R1 int_n after reset", int'(int_n), 0);
        chk("R1 chan_ind after reset", int'(chan_ind), 1);
        rd_sel = 1'b1; #1;
        chk("R1 reg1 after reset", int'(rd_data), 0);

        // R2 reading register 0 clears reset status
        read_reg(1'b0);
        rd_sel = 1'b0; #1;
        chk("R2 reg0 after read", int'(rd_data), 0);
        chk("R2 int_n released", int'(int_n), 1);
        chk("R9 chan held until reg1 read", int'(chan_ind), 1);
        read_reg(1'b1);
        chk("R9 chan cleared after both reads", int'(chan_ind), 0);

        // R3 level change in both directions
        lvl_in = 4'b0001; step();
        chk("R3 rise raises int", int'(int_n), 0);
        rd_sel = 1'b1; #1;
        chk("R3 reg1 shows level", int'(rd_data), 'h02);
        read_reg(1'b1);
        chk("R8 read releases int", int'(int_n), 1);
        lvl_in = 4'b0000; step();
        chk("R3 fall raises int", int'(int_n), 0);
        read_reg(1'b1); read_reg(1'b0);

        // R4 masked source still updates status
        mask1 = 8'h04; lvl_in = 4'b0010; step();
        chk("R4 masked no int", int'(int_n), 1);
        chk("R4 masked no chan", int'(chan_ind), 0);
        rd_sel = 1'b1; #1;
        chk("R4 status updates", int'(rd_data), 'h04);
        mask1 = 8'h00;

        // R5 caller-data request rising only
        cid_req = 1'b1; step();
        chk("R5 rise raises int", int'(int_n), 0);
        read_reg(1'b1); read_reg(1'b0);
        cid_req = 1'b0; step();
        chk("R5 fall no int", int'(int_n), 1);
        chk("R5 fall no chan", int'(chan_ind), 0);

        // R6 persistence filter, R7 latch on completion
        hook_cnt = 8'd3; tick = 1'b1; raw_hook = 1'b1;
        rd_sel = 1'b0;
        step(); step(); step();
        chk("R6 hook not yet filtered", int'(rd_data[0]), 0);
        step();
        chk("R6 hook filtered after count", int'(rd_data[0]), 1);
        chk("R7 filter transition raises int", int'(int_n), 0);
        read_reg(1'b0); read_reg(1'b1);
        raw_hook = 1'b0; step(); step(); step();
        raw_hook = 1'b1; step();
        raw_hook = 1'b0; step(); step(); step();
        rd_sel = 1'b0; #1;
        chk("R6 glitch restarts count", int'(rd_data[0]), 1);
        step();
        chk("R6 hook falls after full count", int'(rd_data[0]), 0);
        read_reg(1'b0); read_reg(1'b1);
        mask0 = 8'h02; lim_cnt = 8'd1; raw_lim = 1'b1;
        step(); step();
        rd_sel = 1'b0; #1;
        chk("R6 limit filtered", int'(rd_data), 'h02);
        chk("R7 masked transition no int", int'(int_n), 1);
        mask0 = 8'h00; tick = 1'b0;

        // R8 event in same cycle as read stays pending
        lvl_in = 4'b0110; read_reg(1'b1);
        chk("R8 collision keeps int", int'(int_n), 0);
        chk("R8 collision keeps chan", int'(chan_ind), 1);
        read_reg(1'b1);
        chk("R8 second read releases int", int'(int_n), 1);
        read_reg(1'b0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tick = (($urandom % 3) == 0);
            if (($urandom % 12) == 0) raw_hook = ~raw_hook;
            if (($urandom % 15) == 0) raw_lim = ~raw_lim;
            if (($urandom % 10) == 0) lvl_in = lvl_in ^ LVL_N'(1 << ($urandom % LVL_N));
            if (($urandom % 8) == 0) cid_req = ~cid_req;
            if (($urandom % 50) == 0) mask0 = 8'($urandom);
            if (($urandom % 50) == 0) mask1 = 8'($urandom);
            if (($urandom % 100) == 0) hook_cnt = 8'($urandom % 5);
            if (($urandom % 100) == 0) lim_cnt = 8'($urandom % 5);
            rd_stb = (($urandom % 4) == 0);
            rd_sel = 1'($urandom);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule